// File: doc/BRIEF.md
# Receive Line Status and Buffer Unit

This unit sits between a serial receive deserializer and a CPU-facing register port. Each completed character arrives as a one-cycle pulse with eight data bits and three error flags: parity, framing and break. In queue mode the unit stores characters in a 16-entry first-in first-out buffer. In single mode it keeps one holding register that a new character overwrites. The character at the head of the buffer is always presented on the read-data output.

The unit keeps an 8-bit line status word and raises a line-status interrupt request when it is enabled. CPU reads of the buffer and of the status word are modelled as one-cycle strobes. A status read returns the value shown in that cycle and then clears the error bits. The two transmit-side empty flags are plain inputs that the unit registers into the status word.

Top module: `rx_line_status`

## Requirements
- R1: The status word layout is: bit 0 data ready, bit 1 overrun, bit 2 parity error, bit 3 framing error, bit 4 break, bit 5 transmit holding empty, bit 6 transmitter empty, bit 7 always 0. After reset the word is 0x60.
- R2: Bits 5 and 6 take the values of `txHoldEmpty` and `txShiftEmpty` one clock after the inputs are sampled.
- R3: Data ready (bit 0) is 1 when at least one unread character is held. It drops after the read strobe takes the last character out.
- R4: In single mode (`fifoMode`=0), a character that arrives while an unread one is held, with no read strobe in that cycle, sets overrun (bit 1) and replaces the held character. A read in the same cycle avoids the overrun.
- R5: In queue mode (`fifoMode`=1), overrun is set only when a character completes while all 16 entries are occupied. That character is discarded, and the stored entries and their order are unchanged.
- R6: Parity, framing and break (bits 2, 3, 4) take the flags of a character when it becomes the head of the buffer. This happens when it is written into an empty buffer, when it is exposed by a read, or when it is loaded in single mode. Once set, these bits stay set until a status read.
- R7: A status-read strobe clears bits 1 to 4 on the following clock edge.
- R8: If a new error occurs in the same cycle as a status read, the read sees the old word and the new error bit stays set afterwards.
- R9: `lineIrq` is 1 exactly when `irqEn` is 1 and any of bits 1 to 4 is set.
- R10: Characters leave in arrival order, and `rxData` shows the head character whenever data ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoMode | input | 1 | 1 = 16-entry queue, 0 = single holding register |
| irqEn | input | 1 | Line-status interrupt enable |
| charValid | input | 1 | One-cycle pulse: a received character is complete |
| charData | input | 8 | Received character |
| charParErr | input | 1 | Parity error flag of the character |
| charFrmErr | input | 1 | Framing error flag of the character |
| charBrk | input | 1 | Break flag of the character |
| bufRead | input | 1 | CPU read strobe for the receive buffer |
| statusRead | input | 1 | CPU read strobe for the status word |
| txHoldEmpty | input | 1 | Transmit holding register empty |
| txShiftEmpty | input | 1 | Transmitter fully idle |
| rxData | output | 8 | Head character of the buffer |
| lineStatus | output | 8 | Line status word |
| lineIrq | output | 1 | Line-status interrupt request |

## Verification
Every status bit, the head data and the occupancy change on the clock edge that samples the strobe. The interrupt is combinational from those registered bits, so it follows on that same edge. The bench drives strobes on the falling edge and holds them for one cycle. It samples every output at the next falling edge, which lies exactly one register stage after the stimulus. Status reads capture the word on the falling edge in which the strobe is raised. That capture is the value the CPU would see, before the clear takes effect.

// File: rtl/rx_status_pkg.sv
package rx_status_pkg;
  localparam int DATA_W = 8;

  // Bit positions inside the line status word
  localparam int LS_DR   = 0;
  localparam int LS_OVR  = 1;
  localparam int LS_PAR  = 2;
  localparam int LS_FRM  = 3;
  localparam int LS_BRK  = 4;
  localparam int LS_THE  = 5;
  localparam int LS_TEMT = 6;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic push;       // write at tail, advance tail
    logic pop;        // advance head
    logic overwrite;  // write at head without pointer change
  } dpStrobe_t;
endpackage

// File: rtl/rx_status_dp.sv
module rx_status_dp
  import rx_status_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  dpStrobe_t strobe,
  input  rxEntry_t  wrEntry,
  output rxEntry_t  headEntry,
  output rxEntry_t  nextEntry
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rxEntry_t       mem [DEPTH];
  logic [AW-1:0]  wrPtr;
  logic [AW-1:0]  rdPtr;
  logic [AW-1:0]  rdPtrNext;
  logic [AW-1:0]  wrPtrNext;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign rdPtrNext = bump(rdPtr);
  assign wrPtrNext = bump(wrPtr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.push) wrPtr <= wrPtrNext;
      if (strobe.pop)  rdPtr <= rdPtrNext;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic hitTail;
    logic hitHead;
    assign hitTail = strobe.push      && (wrPtr == AW'(g));
    assign hitHead = strobe.overwrite && (rdPtr == AW'(g));
    always_ff @(posedge clk) begin
      if (hitTail || hitHead) mem[g] <= wrEntry;
    end
  end

  assign headEntry = mem[rdPtr];
  assign nextEntry = mem[rdPtrNext];
endmodule

// File: rtl/rx_status_ctl.sv
module rx_status_ctl
  import rx_status_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       fifoMode,
  input  logic       irqEn,
  input  logic       charValid,
  input  rxEntry_t   inEntry,
  input  logic       bufRead,
  input  logic       statusRead,
  input  logic       txHoldEmpty,
  input  logic       txShiftEmpty,
  input  rxEntry_t   nextEntry,
  output dpStrobe_t  strobe,
  output logic [7:0] lineStatus,
  output logic       lineIrq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic          isEmpty;
  logic          isFull;
  logic          doPop;
  logic          doPush;
  logic          doOver;
  logic          ovrEvent;
  logic          headArrive;
  rxEntry_t      arriveEntry;

  logic ovrErr, parErr, frmErr, brkErr;
  logic txHoldQ, txShiftQ;

  assign isEmpty = (count == '0);
  assign isFull  = (count == CW'(DEPTH));
  assign doPop   = bufRead && !isEmpty;

  // Accept / overrun decision per mode
  always_comb begin
    if (fifoMode) begin
      ovrEvent = charValid && isFull;
      doPush   = charValid && !isFull;
      doOver   = 1'b0;
    end else begin
      ovrEvent = charValid && !isEmpty && !bufRead;
      doPush   = charValid && !ovrEvent;
      doOver   = ovrEvent;
    end
  end

  assign strobe.push      = doPush;
  assign strobe.pop       = doPop;
  assign strobe.overwrite = doOver;

  // Which character becomes the new head this cycle
  always_comb begin
    headArrive  = 1'b0;
    arriveEntry = inEntry;
    if (doPush && (isEmpty || (doPop && count == CW'(1)))) begin
      headArrive  = 1'b1;
      arriveEntry = inEntry;
    end else if (doPop && count > CW'(1)) begin
      headArrive  = 1'b1;
      arriveEntry = nextEntry;
    end else if (doOver) begin
      headArrive  = 1'b1;
      arriveEntry = inEntry;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (!fifoMode) begin
      if (charValid)  count <= CW'(1);
      else if (doPop) count <= '0;
    end else begin
      count <= count + CW'(doPush) - CW'(doPop);
    end
  end

  // Sticky error bits: clear on status read, a same-cycle set wins
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovrErr   <= 1'b0;
      parErr   <= 1'b0;
      frmErr   <= 1'b0;
      brkErr   <= 1'b0;
      txHoldQ  <= 1'b1;
      txShiftQ <= 1'b1;
    end else begin
      ovrErr   <= (ovrErr & ~statusRead) | ovrEvent;
      parErr   <= (parErr & ~statusRead) | (headArrive & arriveEntry.par);
      frmErr   <= (frmErr & ~statusRead) | (headArrive & arriveEntry.frm);
      brkErr   <= (brkErr & ~statusRead) | (headArrive & arriveEntry.brk);
      txHoldQ  <= txHoldEmpty;
      txShiftQ <= txShiftEmpty;
    end
  end

  always_comb begin
    lineStatus          = '0;
    lineStatus[LS_DR]   = !isEmpty;
    lineStatus[LS_OVR]  = ovrErr;
    lineStatus[LS_PAR]  = parErr;
    lineStatus[LS_FRM]  = frmErr;
    lineStatus[LS_BRK]  = brkErr;
    lineStatus[LS_THE]  = txHoldQ;
    lineStatus[LS_TEMT] = txShiftQ;
  end

  assign lineIrq = irqEn && (ovrErr || parErr || frmErr || brkErr);
endmodule

// File: rtl/rx_line_status.sv
module rx_line_status
  import rx_status_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoMode,
  input  logic              irqEn,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charParErr,
  input  logic              charFrmErr,
  input  logic              charBrk,
  input  logic              bufRead,
  input  logic              statusRead,
  input  logic              txHoldEmpty,
  input  logic              txShiftEmpty,
  output logic [DATA_W-1:0] rxData,
  output logic [7:0]        lineStatus,
  output logic              lineIrq
);
  rxEntry_t  inEntry;
  rxEntry_t  headEntry;
  rxEntry_t  nextEntry;
  dpStrobe_t strobe;

  assign inEntry = '{brk: charBrk, frm: charFrmErr, par: charParErr, data: charData};

  rx_status_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .fifoMode    (fifoMode),
    .irqEn       (irqEn),
    .charValid   (charValid),
    .inEntry     (inEntry),
    .bufRead     (bufRead),
    .statusRead  (statusRead),
    .txHoldEmpty (txHoldEmpty),
    .txShiftEmpty(txShiftEmpty),
    .nextEntry   (nextEntry),
    .strobe      (strobe),
    .lineStatus  (lineStatus),
    .lineIrq     (lineIrq)
  );

  rx_status_dp #(.DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wrEntry  (inEntry),
    .headEntry(headEntry),
    .nextEntry(nextEntry)
  );

  assign rxData = headEntry.data;
endmodule

// File: rtl/rx_line_status_chk.sv
module rx_line_status_chk #(
  parameter int DEPTH = 16
) (
  input logic       clk,
  input logic       rstN,
  input logic       fifoMode,
  input logic       irqEn,
  input logic       charValid,
  input logic [7:0] charData,
  input logic       bufRead,
  input logic       statusRead,
  input logic       txHoldEmpty,
  input logic       txShiftEmpty,
  input logic [7:0] rxData,
  input logic [7:0] lineStatus,
  input logic       lineIrq
);
  localparam int CW = $clog2(DEPTH + 1);

  // Shadow occupancy, kept from the port view only
  logic [CW-1:0] occ;
  always_ff @(posedge clk) begin
    if (!rstN) occ <= '0;
    else if (!fifoMode) begin
      if (charValid) occ <= CW'(1);
      else if (bufRead && occ != '0) occ <= '0;
    end else begin
      occ <= occ + CW'(charValid && occ != CW'(DEPTH)) - CW'(bufRead && occ != '0);
    end
  end

  // R2
  tx_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (lineStatus[5] == $past(txHoldEmpty)) && (lineStatus[6] == $past(txShiftEmpty)));

  // R3
  dr_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufRead && occ == CW'(1) && !charValid) |=> !lineStatus[0]);

  // R4
  single_ovr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!fifoMode && occ == CW'(1) && charValid && !bufRead) |=> lineStatus[1] && (rxData == $past(charData)));

  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fifoMode && occ == CW'(DEPTH) && charValid && !bufRead) |=> lineStatus[1] && $stable(rxData));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !charValid) |=> !lineStatus[1]);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !irqEn |-> !lineIrq);
endmodule

bind rx_line_status rx_line_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .fifoMode    (fifoMode),
  .irqEn       (irqEn),
  .charValid   (charValid),
  .charData    (charData),
  .bufRead     (bufRead),
  .statusRead  (statusRead),
  .txHoldEmpty (txHoldEmpty),
  .txShiftEmpty(txShiftEmpty),
  .rxData      (rxData),
  .lineStatus  (lineStatus),
  .lineIrq     (lineIrq)
);

// File: tb/sim_rx_line_status.sv
module sim_rx_line_status;
  logic       clk = 1'b0;
  logic       rstN;
  logic       fifoMode, irqEn, charValid, charParErr, charFrmErr, charBrk;
  logic [7:0] charData;
  logic       bufRead, statusRead, txHoldEmpty, txShiftEmpty;
  logic [7:0] rxData, lineStatus;
  logic       lineIrq;

  int errCount = 0;
  int chkCount = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_line_status u0 (
    .clk(clk), .rstN(rstN), .fifoMode(fifoMode), .irqEn(irqEn),
    .charValid(charValid), .charData(charData), .charParErr(charParErr),
    .charFrmErr(charFrmErr), .charBrk(charBrk), .bufRead(bufRead),
    .statusRead(statusRead), .txHoldEmpty(txHoldEmpty), .txShiftEmpty(txShiftEmpty),
    .rxData(rxData), .lineStatus(lineStatus), .lineIrq(lineIrq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCount++;
    if (act !== exp) begin
      errCount++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errCount, chkCount);
      $finish;
    end
  endtask

  // All tasks start and end on a falling edge
  task automatic sendChar(input logic [7:0] d, input logic p, input logic f, input logic b);
    charValid = 1'b1; charData = d; charParErr = p; charFrmErr = f; charBrk = b;
    @(negedge clk);
    charValid = 1'b0; charParErr = 1'b0; charFrmErr = 1'b0; charBrk = 1'b0;
  endtask

  task automatic popExpect(input logic [7:0] exp, input string req);
    check(req, {31'd0, lineStatus[0]}, 32'd1);
    check(req, {24'd0, rxData}, {24'd0, exp});
    bufRead = 1'b1;
    @(negedge clk);
    bufRead = 1'b0;
  endtask

  task automatic readStatus(output logic [7:0] seen);
    seen = lineStatus;
    statusRead = 1'b1;
    @(negedge clk);
    statusRead = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset word", {24'd0, lineStatus}, 32'h60);
    check("R9 reset irq", {31'd0, lineIrq}, 32'd0);
  endtask

  task automatic testTxBits();
    txHoldEmpty = 1'b0;
    @(negedge clk);
    check("R2 hold empty low", {24'd0, lineStatus}, 32'h40);
    txShiftEmpty = 1'b0;
    @(negedge clk);
    check("R2 shift empty low", {24'd0, lineStatus}, 32'h00);
    txHoldEmpty = 1'b1; txShiftEmpty = 1'b1;
    @(negedge clk);
    check("R1 bit7 zero, tx restored", {24'd0, lineStatus}, 32'h60);
  endtask

  task automatic testSingleChar();
    sendChar(8'hA5, 0, 0, 0);
    check("R3 ready set", {24'd0, lineStatus}, 32'h61);
    popExpect(8'hA5, "R10 single char");
    check("R3 ready clear", {24'd0, lineStatus}, 32'h60);
  endtask

  task automatic testFillOverrun();
    logic [7:0] seen;
    for (int i = 0; i < 16; i++) sendChar(8'h10 + 8'(i), 0, 0, 0);
    check("R5 full no overrun", {24'd0, lineStatus}, 32'h61);
    sendChar(8'hEE, 1, 1, 1);
    check("R5 overrun set", {24'd0, lineStatus}, 32'h63);
    check("R5 head intact", {24'd0, rxData}, 32'h10);
    check("R9 irq gated off", {31'd0, lineIrq}, 32'd0);
    readStatus(seen);
    check("R7 read sees overrun", {24'd0, seen}, 32'h63);
    check("R7 overrun cleared", {24'd0, lineStatus}, 32'h61);
    for (int i = 0; i < 16; i++) popExpect(8'h10 + 8'(i), "R5 R10 order kept");
    check("R5 dropped char absent", {24'd0, lineStatus}, 32'h60);
  endtask

  task automatic testHeadFlags();
    logic [7:0] seen;
    sendChar(8'h31, 0, 0, 0);
    sendChar(8'h32, 1, 0, 0);
    check("R6 parity waits for head", {24'd0, lineStatus}, 32'h61);
    popExpect(8'h31, "R10 first");
    check("R6 parity at head", {24'd0, lineStatus}, 32'h65);
    check("R9 irq disabled", {31'd0, lineIrq}, 32'd0);
    readStatus(seen);
    check("R7 parity read", {24'd0, seen}, 32'h65);
    check("R7 parity cleared", {24'd0, lineStatus}, 32'h61);
    popExpect(8'h32, "R10 second");
    sendChar(8'h33, 0, 1, 0);
    check("R6 framing into empty", {24'd0, lineStatus}, 32'h69);
    sendChar(8'h34, 0, 0, 1);
    check("R6 break not yet head", {24'd0, lineStatus}, 32'h69);
    readStatus(seen);
    check("R7 framing cleared", {24'd0, lineStatus}, 32'h61);
    popExpect(8'h33, "R10 third");
    check("R6 break at head", {24'd0, lineStatus}, 32'h71);
    readStatus(seen);
    check("R7 break cleared", {24'd0, lineStatus}, 32'h61);
    popExpect(8'h34, "R10 fourth");
    check("R3 empty again", {24'd0, lineStatus}, 32'h60);
  endtask

  task automatic testSameCycle();
    logic [7:0] seen;
    irqEn = 1'b1;
    seen = lineStatus;
    statusRead = 1'b1;
    sendChar(8'h44, 1, 0, 0);
    statusRead = 1'b0;
    check("R8 read saw old word", {24'd0, seen}, 32'h60);
    check("R8 new error kept", {24'd0, lineStatus}, 32'h65);
    check("R9 irq raised", {31'd0, lineIrq}, 32'd1);
    readStatus(seen);
    check("R9 irq cleared", {31'd0, lineIrq}, 32'd0);
    popExpect(8'h44, "R10 same-cycle char");
    irqEn = 1'b0;
  endtask

  task automatic testSingleMode();
    logic [7:0] seen;
    fifoMode = 1'b0;
    sendChar(8'h51, 0, 0, 0);
    sendChar(8'h52, 0, 0, 0);
    check("R4 overrun single", {24'd0, lineStatus}, 32'h63);
    check("R4 overwritten", {24'd0, rxData}, 32'h52);
    readStatus(seen);
    popExpect(8'h52, "R4 read latest");
    check("R4 empty", {24'd0, lineStatus}, 32'h60);
    sendChar(8'h53, 0, 1, 0);
    check("R6 single flags", {24'd0, lineStatus}, 32'h69);
    readStatus(seen);
    bufRead = 1'b1;
    sendChar(8'h55, 0, 0, 0);
    bufRead = 1'b0;
    check("R4 read avoids overrun", {24'd0, lineStatus}, 32'h61);
    check("R4 new char held", {24'd0, rxData}, 32'h55);
    popExpect(8'h55, "R3 single read");
    check("R3 single clear", {24'd0, lineStatus}, 32'h60);
    fifoMode = 1'b1;
  endtask

  initial begin
    #2000000;
    errCount++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
  end

  initial begin
    rstN = 1'b0; fifoMode = 1'b1; irqEn = 1'b0; charValid = 1'b0; charData = '0;
    charParErr = 1'b0; charFrmErr = 1'b0; charBrk = 1'b0; bufRead = 1'b0;
    statusRead = 1'b0; txHoldEmpty = 1'b1; txShiftEmpty = 1'b1;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTxBits();
    testSingleChar();
    testFillOverrun();
    testHeadFlags();
    testSameCycle();
    testSingleMode();
    summary();
  end
endmodule